// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA Channel

This block is one playback bus-master channel. It walks a ring of 32 buffer descriptors held in system memory. For each entry it reads the descriptor over a single-outstanding memory read port, then fetches the entry's 32-bit stereo sample words one by one. Each word is presented on a ready/valid stream toward a codec FIFO.

Software programs the ring base, a last-valid index and a control byte through a small word-addressed register port. It then watches the current and prefetched indices, a status byte and the count of samples left in the active buffer.

The walk stops after the buffer whose index equals the last-valid index, and the channel marks itself halted. While halted at the end, the output keeps offering either silence or the final sample, as chosen by a policy bit in that final descriptor. Moving the last-valid index on from the halted position restarts the walk at the next entry. Completion and FIFO-fault events are latched in write-one-to-clear status bits, and each of them can be routed to a single interrupt line.

Top module: `adma_ring_chan`

## Requirements
- R1: After reset the status word (byte 0x08) reads 0x03, the index word (0x04) reads 0x00010000, control (0x10) reads 0, `irq` is 0 and `smp_valid` is 0.
- R2: Descriptor n is read as two dwords at base + 8*n. The first dword supplies the buffer address, with bits 1:0 ignored. In the second dword, bit 31 is the completion-interrupt flag, bit 30 is the silence policy and bits 15:0 are the length in samples. The samples are read from consecutive dwords and leave on `smp_data` in order, one per `smp_valid && smp_ready` cycle.
- R3: An entry whose length is zero emits no sample, and the walk moves straight on.
- R4: The index word holds the current index in bits 4:0, the last-valid index in bits 12:8 (the only writable field) and the prefetched index in bits 20:16. The prefetched index always equals the current index plus one, modulo 32, and the current index wraps from 31 to 0.
- R5: When the buffer whose index equals the last-valid index completes, status bit 2 and status bit 0 (halted) are set and no further entry is fetched.
- R6: Status bit 1 reads 1 exactly while the current index equals the last-valid index. Writing that bit has no effect.
- R7: Status bit 3 is set when an entry with the completion flag set finishes. Bits 2, 3 and 4 clear when 1 is written to them and are left unchanged when 0 is written. A set event in the same cycle as a clearing write wins.
- R8: A high `fifo_fault` in a cycle sets status bit 4.
- R9: Control bit 0 runs the channel. While it is 0, `smp_valid` stays low.
- R10: Writing control with bit 1 set, while control bit 0 currently reads 0, clears the base, the indices, the remaining count and the status (status then reads 0x03). Bits 4:2 take the written value, and bits 1:0 read 0 afterwards. While control bit 0 reads 1, bit 1 is ignored.
- R11: `irq` is high exactly when (status bit 2 and control bit 2) or (status bit 4 and control bit 3) or (status bit 3 and control bit 4).
- R12: The remaining-count word (0x0C, bits 15:0) equals the buffer length minus the samples already accepted from the current buffer.
- R13: While halted at the end with run set, `smp_valid` is high. `smp_data` is zero if the final entry's silence bit was 1, and repeats that entry's last sample otherwise. Handshakes in this state change no index, count or status.
- R14: While halted at the end, writing a last-valid index that differs from the current index clears status bit 0 and resumes the walk at the current index plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte address (bits 1:0 ignored) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_addr | output | AW | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| smp_valid | output | 1 | Sample word valid |
| smp_ready | input | 1 | Sink accepts the sample word |
| smp_data | output | 32 | Stereo sample word |
| fifo_fault | input | 1 | Codec FIFO overrun/underrun pulse |
| irq | output | 1 | Interrupt request |

## Verification
The overlap that matters most is a FIFO-fault event landing in the same cycle as a software write that clears status bit 4. The bench raises `fifo_fault` on the very cycle it writes 0x10 to the status word. It expects the bit to remain set and the interrupt to stay high, and a later clearing write with no fault must then drop both. A second overlap is a last-valid write arriving while the channel sits halted at the end. This must both clear the halted bit and advance the current index in the same edge, and it is judged through the index word and the sample stream that follows.

// File: rtl/adma_pkg.sv
package adma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESC_A,
      ST_DESC_B,
      ST_FETCH,
      ST_SEND,
      ST_DONE
   } eng_state_t;

   // word select values, reg_addr[4:2]
   localparam logic [2:0] RS_BASE   = 3'd0;
   localparam logic [2:0] RS_INDEX  = 3'd1;
   localparam logic [2:0] RS_STATUS = 3'd2;
   localparam logic [2:0] RS_REMAIN = 3'd3;
   localparam logic [2:0] RS_CTRL   = 3'd4;

   // status bits
   localparam int SB_HALT     = 0;
   localparam int SB_ATLAST   = 1;
   localparam int SB_LASTDONE = 2;
   localparam int SB_BUFDONE  = 3;
   localparam int SB_FIFOERR  = 4;

   // control bits
   localparam int CB_RUN     = 0;
   localparam int CB_CLEAR   = 1;
   localparam int CB_IE_LAST = 2;
   localparam int CB_IE_FIFO = 3;
   localparam int CB_IE_BUF  = 4;

   // descriptor word 1 flags
   localparam int DF_IRQ = 31;
   localparam int DF_SIL = 30;

   // index word field positions
   localparam int IX_LAST_LSB = 8;
   localparam int IX_PRE_LSB  = 16;

   typedef struct packed {
      logic start;
      logic advance;
      logic buf_done;
      logic last_done;
   } eng_evt_t;

endpackage

// File: rtl/adma_regfile.sv
module adma_regfile
   import adma_pkg::*;
#(
   parameter int IDX_W          = 5,
   parameter int AW             = 32,
   parameter int LEN_W          = 16,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       reg_addr,
   input  logic             reg_we,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             fifo_fault,
   input  eng_evt_t         evt,
   input  logic             in_done,
   input  logic [LEN_W-1:0] remain,
   output logic [AW-1:0]    base,
   output logic [IDX_W-1:0] cur_idx,
   output logic [IDX_W-1:0] last_idx,
   output logic             run,
   output logic             halted,
   output logic             soft_rst,
   output logic             resume,
   output logic             irq
);

   logic [AW-1:0]    base_q;
   logic [IDX_W-1:0] cur_q, pre_q, last_q;
   logic             halt_q, lastdone_q, bufdone_q, fifoerr_q;
   logic             run_q;
   logic [2:0]       ie_q;
   logic [2:0]       wsel;
   logic             wr_base, wr_index, wr_stat, wr_ctrl;
   logic [IDX_W-1:0] wr_last;
   logic             irq_comb;

   assign wsel     = reg_addr[4:2];
   assign wr_base  = reg_we && (wsel == RS_BASE);
   assign wr_index = reg_we && (wsel == RS_INDEX);
   assign wr_stat  = reg_we && (wsel == RS_STATUS);
   assign wr_ctrl  = reg_we && (wsel == RS_CTRL);
   assign wr_last  = reg_wdata[IX_LAST_LSB +: IDX_W];

   assign soft_rst = wr_ctrl && reg_wdata[CB_CLEAR] && !run_q;
   assign resume   = wr_index && in_done && (wr_last != cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q      <= '0;
         cur_q       <= '0;
         pre_q       <= IDX_W'(1);
         last_q      <= '0;
         halt_q      <= 1'b1;
         lastdone_q  <= 1'b0;
         bufdone_q   <= 1'b0;
         fifoerr_q   <= 1'b0;
         run_q       <= 1'b0;
         ie_q        <= '0;
      end else if (soft_rst) begin
         base_q      <= '0;
         cur_q       <= '0;
         pre_q       <= IDX_W'(1);
         last_q      <= '0;
         halt_q      <= 1'b1;
         lastdone_q  <= 1'b0;
         bufdone_q   <= 1'b0;
         fifoerr_q   <= 1'b0;
         run_q       <= 1'b0;
         ie_q        <= reg_wdata[CB_IE_BUF:CB_IE_LAST];
      end else begin
         if (wr_base)
            base_q <= {reg_wdata[AW-1:3], 3'b000};
         if (wr_index)
            last_q <= wr_last;
         if (wr_ctrl) begin
            run_q <= reg_wdata[CB_RUN];
            ie_q  <= reg_wdata[CB_IE_BUF:CB_IE_LAST];
         end
         if (evt.advance || resume) begin
            cur_q <= cur_q + IDX_W'(1);
            pre_q <= pre_q + IDX_W'(1);
         end
         if (evt.start || resume)
            halt_q <= 1'b0;
         else if (evt.last_done)
            halt_q <= 1'b1;
         lastdone_q <= (lastdone_q & ~(wr_stat & reg_wdata[SB_LASTDONE])) | evt.last_done;
         bufdone_q  <= (bufdone_q  & ~(wr_stat & reg_wdata[SB_BUFDONE]))  | evt.buf_done;
         fifoerr_q  <= (fifoerr_q  & ~(wr_stat & reg_wdata[SB_FIFOERR]))  | fifo_fault;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (wsel)
         RS_BASE:   reg_rdata = 32'(base_q);
         RS_INDEX: begin
            reg_rdata[IDX_W-1:0]                = cur_q;
            reg_rdata[IX_LAST_LSB +: IDX_W]     = last_q;
            reg_rdata[IX_PRE_LSB +: IDX_W]      = pre_q;
         end
         RS_STATUS: reg_rdata[4:0] = {fifoerr_q, bufdone_q, lastdone_q,
                                      (cur_q == last_q), halt_q};
         RS_REMAIN: reg_rdata[LEN_W-1:0] = remain;
         RS_CTRL:   reg_rdata[4:0] = {ie_q, 1'b0, run_q};
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_comb = (lastdone_q & ie_q[0]) | (fifoerr_q & ie_q[1]) | (bufdone_q & ie_q[2]);

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_comb;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_comb;
      end
   endgenerate

   assign base     = base_q;
   assign cur_idx  = cur_q;
   assign last_idx = last_q;
   assign run      = run_q;
   assign halted   = halt_q;

endmodule

// File: rtl/adma_engine.sv
module adma_engine
   import adma_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter int AW    = 32,
   parameter int LEN_W = 16,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             soft_rst,
   input  logic             resume,
   input  logic [AW-1:0]    base,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [IDX_W-1:0] last_idx,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   input  logic             mem_rvalid,
   input  logic [DW-1:0]    mem_rdata,
   output logic             smp_valid,
   input  logic             smp_ready,
   output logic [DW-1:0]    smp_data,
   output eng_evt_t         evt,
   output logic             in_done,
   output logic [LEN_W-1:0] remain
);

   localparam int PAD_W = AW - IDX_W - 3;

   eng_state_t       state_q;
   logic [AW-1:0]    ptr_q;
   logic [LEN_W-1:0] remain_q;
   logic [DW-1:0]    hold_q;
   logic             irq_flag_q, sil_q;
   logic             finish, at_last, ioc_now, accept;
   logic [AW-1:0]    desc_addr;

   assign at_last   = (cur_idx == last_idx);
   assign accept    = run && smp_ready && (state_q == ST_SEND);
   assign desc_addr = base + {{PAD_W{1'b0}}, cur_idx, 3'b000};
   assign ioc_now   = (state_q == ST_DESC_B) ? mem_rdata[DF_IRQ] : irq_flag_q;

   always_comb begin
      finish = 1'b0;
      evt    = '0;
      case (state_q)
         ST_IDLE:   evt.start = run;
         ST_DESC_B: finish = mem_rvalid && (mem_rdata[LEN_W-1:0] == '0);
         ST_SEND:   finish = accept && (remain_q == LEN_W'(1));
         default:   finish = 1'b0;
      endcase
      if (finish) begin
         evt.buf_done  = ioc_now;
         evt.last_done = at_last;
         evt.advance   = !at_last;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ptr_q      <= '0;
         remain_q   <= '0;
         hold_q     <= '0;
         irq_flag_q <= 1'b0;
         sil_q      <= 1'b0;
      end else if (soft_rst) begin
         state_q    <= ST_IDLE;
         ptr_q      <= '0;
         remain_q   <= '0;
         hold_q     <= '0;
         irq_flag_q <= 1'b0;
         sil_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE:
               if (run) state_q <= ST_DESC_A;
            ST_DESC_A:
               if (mem_rvalid) begin
                  ptr_q   <= {mem_rdata[AW-1:2], 2'b00};
                  state_q <= ST_DESC_B;
               end
            ST_DESC_B:
               if (mem_rvalid) begin
                  irq_flag_q <= mem_rdata[DF_IRQ];
                  sil_q      <= mem_rdata[DF_SIL];
                  remain_q   <= mem_rdata[LEN_W-1:0];
                  if (finish) state_q <= at_last ? ST_DONE : ST_DESC_A;
                  else        state_q <= ST_FETCH;
               end
            ST_FETCH:
               if (mem_rvalid) begin
                  hold_q  <= mem_rdata;
                  state_q <= ST_SEND;
               end
            ST_SEND:
               if (accept) begin
                  ptr_q    <= ptr_q + AW'(4);
                  remain_q <= remain_q - LEN_W'(1);
                  if (finish) state_q <= at_last ? ST_DONE : ST_DESC_A;
                  else        state_q <= ST_FETCH;
               end
            ST_DONE:
               if (resume) state_q <= ST_DESC_A;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = '0;
      case (state_q)
         ST_DESC_A: begin mem_req = 1'b1; mem_addr = desc_addr; end
         ST_DESC_B: begin mem_req = 1'b1; mem_addr = desc_addr + AW'(4); end
         ST_FETCH:  begin mem_req = 1'b1; mem_addr = ptr_q; end
         default:   begin mem_req = 1'b0; mem_addr = '0; end
      endcase
   end

   assign smp_valid = run && ((state_q == ST_SEND) || (state_q == ST_DONE));
   assign smp_data  = ((state_q == ST_DONE) && sil_q) ? '0 : hold_q;
   assign in_done   = (state_q == ST_DONE);
   assign remain    = remain_q;

endmodule

// File: rtl/adma_ring_chan.sv
module adma_ring_chan
   import adma_pkg::*;
#(
   parameter int IDX_W          = 5,
   parameter int AW             = 32,
   parameter int LEN_W          = 16,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [4:0]    reg_addr,
   input  logic          reg_we,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   output logic          smp_valid,
   input  logic          smp_ready,
   output logic [31:0]   smp_data,
   input  logic          fifo_fault,
   output logic          irq
);

   localparam int N_DESC = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("adma_ring_chan: IDX_W must lie in 1..8");
      end
      if (AW > 32 || AW < IDX_W + 4) begin : g_bad_aw
         $error("adma_ring_chan: AW must hold the ring and fit 32 bits");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("adma_ring_chan: LEN_W must lie in 1..16");
      end
      if (N_DESC * 8 > (1 << (AW > 30 ? 30 : AW))) begin : g_bad_ring
         $error("adma_ring_chan: ring exceeds address space");
      end
   endgenerate

   eng_evt_t         evt_w;
   logic             in_done_w, run_w, halted_w, soft_rst_w, resume_w;
   logic [LEN_W-1:0] remain_w;
   logic [AW-1:0]    base_w;
   logic [IDX_W-1:0] cur_w, last_w;

   adma_regfile #(
      .IDX_W(IDX_W), .AW(AW), .LEN_W(LEN_W), .IRQ_REGISTERED(IRQ_REGISTERED)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fifo_fault(fifo_fault), .evt(evt_w), .in_done(in_done_w), .remain(remain_w),
      .base(base_w), .cur_idx(cur_w), .last_idx(last_w), .run(run_w),
      .halted(halted_w), .soft_rst(soft_rst_w), .resume(resume_w), .irq(irq)
   );

   adma_engine #(
      .IDX_W(IDX_W), .AW(AW), .LEN_W(LEN_W), .DW(32)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .run(run_w), .soft_rst(soft_rst_w), .resume(resume_w),
      .base(base_w), .cur_idx(cur_w), .last_idx(last_w),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
      .evt(evt_w), .in_done(in_done_w), .remain(remain_w)
   );

endmodule

// File: rtl/adma_ring_chan_chk.sv
module adma_ring_chan_chk #(
   parameter int AW    = 32,
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             soft_rst,
   input logic             halted,
   input logic             in_done,
   input logic             last_done,
   input logic             smp_valid,
   input logic             smp_ready,
   input logic [LEN_W-1:0] remain,
   input logic             mem_req,
   input logic             mem_rvalid,
   input logic [AW-1:0]    mem_addr
);

   // R9
   run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !smp_valid);

   // R12
   remain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready && remain > LEN_W'(1)) |=> (remain == $past(remain) - LEN_W'(1)));

   // R5
   last_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_done |=> halted);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid && !soft_rst) |=> (mem_req && $stable(mem_addr)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !in_done) |-> !smp_valid);

endmodule

bind adma_ring_chan adma_ring_chan_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_w), .soft_rst(soft_rst_w),
   .halted(halted_w), .in_done(in_done_w), .last_done(evt_w.last_done),
   .smp_valid(smp_valid), .smp_ready(smp_ready), .remain(remain_w),
   .mem_req(mem_req), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr)
);

// File: tb/adma_ring_chan_tb.sv
`timescale 1ns/1ps
module adma_ring_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        smp_valid;
   logic        smp_ready = 1'b0;
   logic [31:0] smp_data;
   logic        fifo_fault = 1'b0;
   logic        irq;

   logic [31:0] mem [0:511];
   logic [31:0] exp_d [0:255];
   logic [31:0] exp_r [0:255];
   int          n_exp = 0;
   int          n_chk = 0;
   int          n_err = 0;
   logic [31:0] rv;
   logic [31:0] last_smp;

   always #4 clk = ~clk;

   adma_ring_chan u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
      .fifo_fault(fifo_fault), .irq(irq)
   );

   always @(posedge clk) begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= mem[mem_addr[10:2]];
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(input int idx, input logic [31:0] buf_a, input logic [15:0] len,
                           input logic ioc, input logic sil);
      mem[idx*2]   = buf_a;
      mem[idx*2+1] = {ioc, sil, 14'd0, len};
   endtask

   task automatic add_buf(input logic [31:0] buf_a, input int len);
      for (int j = 0; j < len; j++) begin
         mem[(buf_a >> 2) + j] = $urandom;
         exp_d[n_exp] = mem[(buf_a >> 2) + j];
         exp_r[n_exp] = 32'(len - j);
         n_exp++;
      end
   endtask

   task automatic stream(input string tag);
      int got = 0;
      int guard = 0;
      reg_addr = 5'h0C;
      while (got < n_exp && guard < 20000) begin
         @(negedge clk);
         smp_ready = ($urandom % 4) != 0;
         #1;
         if (smp_valid && smp_ready) begin
            chk({tag, " R2 sample"}, smp_data, exp_d[got]);
            chk("R12 remaining count", reg_rdata, exp_r[got]);
            last_smp = exp_d[got];
            got++;
         end
         guard++;
      end
      if (got < n_exp) chk({tag, " R2 stream stalled"}, 32'(got), 32'(n_exp));
      @(posedge clk);
      #1 smp_ready = 1'b0;
      n_exp = 0;
   endtask

   task automatic wait_halt(input string tag);
      logic [31:0] s;
      int guard = 0;
      s = '0;
      while (guard < 3000) begin
         rd(5'h08, s);
         if (s[0]) break;
         guard++;
      end
      chk({tag, " R5 halt reached"}, {31'd0, s[0]}, 32'd1);
   endtask

   initial begin
      #(8 * 150000);
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic any_ioc;
      int   len0;
      rv = $urandom(32'd20250611);
      for (int i = 0; i < 512; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(5'h08, rv); chk("R1 status", rv, 32'h03);
      rd(5'h04, rv); chk("R1 index", rv, 32'h00010000);
      rd(5'h10, rv); chk("R1 control", rv, 32'h0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 valid", {31'd0, smp_valid}, 32'd0);

      // directed walk: entry1 empty (R3), entry2 silent tail
      put_desc(0, 32'h200, 16'd3, 1'b1, 1'b0); add_buf(32'h200, 3);
      put_desc(1, 32'h220, 16'd0, 1'b0, 1'b0);
      put_desc(2, 32'h240, 16'd2, 1'b0, 1'b1); add_buf(32'h240, 2);
      wr(5'h00, 32'h0);
      wr(5'h04, 32'h0200);
      wr(5'h10, 32'h1D);
      stream("R3 walk");
      wait_halt("first walk");
      @(negedge clk);
      chk("R13 silent valid", {31'd0, smp_valid}, 32'd1);
      chk("R13 silent data", smp_data, 32'h0);
      smp_ready = 1'b1;
      repeat (3) @(negedge clk);
      smp_ready = 1'b0;
      rd(5'h04, rv); chk("R13 index unchanged", rv, 32'h00030202);
      rd(5'h08, rv); chk("R5 R6 status at end", rv, 32'h0F);
      chk("R11 irq set", {31'd0, irq}, 32'd1);

      // R7 write-one-to-clear
      wr(5'h08, 32'h04); rd(5'h08, rv); chk("R7 clear bit2", rv, 32'h0B);
      wr(5'h08, 32'h00); rd(5'h08, rv); chk("R7 zero write", rv, 32'h0B);
      wr(5'h08, 32'h08); rd(5'h08, rv); chk("R7 clear bit3", rv, 32'h03);
      chk("R11 irq clear", {31'd0, irq}, 32'd0);

      // R8 fault in the same cycle as its clearing write
      @(negedge clk);
      reg_addr = 5'h08; reg_wdata = 32'h10; reg_we = 1'b1; fifo_fault = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; fifo_fault = 1'b0;
      rd(5'h08, rv); chk("R8 set wins over clear", rv, 32'h13);
      chk("R11 irq on fifo", {31'd0, irq}, 32'd1);
      wr(5'h08, 32'h10); rd(5'h08, rv); chk("R7 clear bit4", rv, 32'h03);

      // R14 resume from halted end, non-silent tail
      put_desc(3, 32'h280, 16'd2, 1'b0, 1'b0); add_buf(32'h280, 2);
      wr(5'h04, 32'h0300);
      rd(5'h08, rv); chk("R14 halt cleared", rv, 32'h02);
      rd(5'h04, rv); chk("R14 R4 index after resume", rv, 32'h00040303);
      stream("R14 resume");
      wait_halt("resume walk");
      rd(5'h08, rv); chk("R14 status at end", rv, 32'h07);
      @(negedge clk);
      chk("R13 repeat data", smp_data, last_smp);

      // R6 read-only bit
      wr(5'h08, 32'h06); rd(5'h08, rv); chk("R6 bit1 unaffected", rv, 32'h03);

      // R10 clear ignored while running
      wr(5'h10, 32'h1F);
      rd(5'h10, rv); chk("R10 ignored control", rv, 32'h1D);
      rd(5'h04, rv); chk("R10 ignored index", rv, 32'h00040303);
      // R9 pause
      wr(5'h10, 32'h1C);
      @(negedge clk); chk("R9 paused valid", {31'd0, smp_valid}, 32'd0);
      // R10 honoured
      wr(5'h10, 32'h1E);
      rd(5'h10, rv); chk("R10 control kept", rv, 32'h1C);
      rd(5'h04, rv); chk("R10 index cleared", rv, 32'h00010000);
      rd(5'h08, rv); chk("R10 status cleared", rv, 32'h03);
      rd(5'h0C, rv); chk("R10 remain cleared", rv, 32'h0);

      // random full ring walk and wrap (R4)
      any_ioc = 1'b0;
      len0 = 0;
      for (int i = 0; i < 32; i++) begin
         int l;
         logic c;
         l = $urandom % 4;
         c = $urandom % 2;
         if (i == 0) len0 = l;
         any_ioc |= c;
         put_desc(i, 32'h400 + 32'(i * 16), 16'(l), c, 1'($urandom % 2));
         add_buf(32'h400 + 32'(i * 16), l);
      end
      wr(5'h04, 32'h1F00);
      wr(5'h10, 32'h1D);
      stream("R4 random ring");
      wait_halt("ring walk");
      rd(5'h04, rv); chk("R4 index at 31", rv, 32'h00001F1F);
      rd(5'h08, rv); chk("R7 status after ring", rv, any_ioc ? 32'h0F : 32'h07);
      wr(5'h08, 32'h1C);
      add_buf(32'h400, len0);
      wr(5'h04, 32'h0000);
      stream("R4 wrapped entry");
      wait_halt("wrap walk");
      rd(5'h04, rv); chk("R4 wrap to 0", rv, 32'h00010000);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule